// File: doc/BRIEF.md
# Accumulator Operate Micro-Sequencer

This block runs the operate class of a 12-bit accumulator machine. One instruction word holds several micro-operations. The block carries them out in a fixed sequence of one-clock stages on a working copy of the accumulator, the link bit and the program counter. A controller places the instruction word, the current accumulator, link, program counter and the console switch word on the inputs. It then pulses `start` and collects the results when `done` rises.

Instruction bits are numbered 0 (most significant) to 11 (least significant). IR bit k is therefore port bit `ir_in[11-k]`. Accumulator bit 0 is `acc_in[11]`.

Two families of word are handled:

- **Rotate family.** IR bit 3 is 0. It clears and complements the accumulator and the link, then rotates the 13-bit value {link, accumulator}, then optionally increments it.
- **Test family.** IR bit 3 is 1 and IR bit 11 is 0. It evaluates a skip test, optionally clears the accumulator, ORs in the switches and may request a halt.

Every other word completes at once with nothing changed.

Top module: `opr_unit`

The state machine has eight states:

- `ST_IDLE` waits for `start`. From there it goes to `ST_G1_CC` (rotate family), to `ST_G2_SKIP` (test family), or to `ST_DONE` (any other word).
- The rotate family runs `ST_G1_CC` → `ST_G1_ROT` → `ST_G1_INC` → `ST_DONE`.
- The test family runs `ST_G2_SKIP` → `ST_G2_OSR` → `ST_G2_HLT` → `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

## Requirements
- R1: After reset, `acc_out`, `link_out`, `pc_out`, `halt_out`, `done` and `busy` are all 0.
- R2: In the rotate family, the accumulator action is chosen by the pair value 2·IR4 + IR6. The value 1 complements the accumulator, 2 clears it, 3 sets it to octal 7777, and 0 leaves it unchanged.
- R3: In the rotate family, the link action is chosen by the pair value 2·IR5 + IR7. The value 1 complements the link, 2 clears it, 3 sets it to 1, and 0 leaves it unchanged.
- R4: The field IR8..IR10, read as a 3-bit number with IR8 most significant, rotates the 13-bit value {link, accumulator}, with the link as the most significant bit. The value 2 rotates left by one place, 3 left by two, 4 right by one and 5 right by two. The values 0, 1, 6 and 7 leave it unchanged.
- R5: In the rotate family, IR11 adds 1 to the 13-bit value {link, accumulator}, modulo 2^13, so that a carry out of the accumulator flips the link.
- R6: The rotate-family stages act in this order: clear/complement, then rotate, then increment. Each stage sees the result of the stage before it. The program counter and the halt output stay unchanged.
- R7: In the test family, the skip test is (IR5 and accumulator bit 0) or (IR6 and accumulator equal to zero) or (IR7 and link). The program counter increments, modulo 2^12, when the skip test XOR IR8 is 1. The test uses the accumulator value from before any clear in the same word.
- R8: In the test family, IR4 clears the accumulator.
- R9: In the test family, IR9 ORs the switch word into the accumulator after the IR4 clear. When both are set, the result equals the switches.
- R10: In the test family, IR10 sets `halt_out` to 1 by the cycle `done` is high. The link never changes in the test family.
- R11: Rotate- and test-family words raise `done` in the fourth cycle after the one in which `start` is sampled, for exactly one cycle. `busy` is high while a stage is running.
- R12: A word whose IR0..IR2 is not 7, or whose IR3 and IR11 are both 1, raises `done` in the first cycle after `start` is sampled. All outputs then equal the inputs, and `halt_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample inputs and begin, accepted only in `ST_IDLE` |
| ir_in | input | 12 | Instruction word, IR bit k on `ir_in[11-k]` |
| acc_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link bit before the instruction |
| pc_in | input | 12 | Program counter (already advanced past this word) |
| sw_in | input | 12 | Console switch word |
| acc_out | output | 12 | Resulting accumulator |
| link_out | output | 1 | Resulting link |
| pc_out | output | 12 | Resulting program counter |
| halt_out | output | 1 | Halt request |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A stage is in progress |

## Verification
Two pairs of actions can coincide in one stage.

In the test family, the skip test and the accumulator clear fall in the same cycle. Words that combine IR4 with the zero or sign test are driven with both zero and non-zero accumulators. The skip must follow the value from before the clear, so a non-zero accumulator gives no skip even though the accumulator ends at zero.

In the rotate family, clear and complement of the same register meet in one stage. This is provoked with pair value 3 and judged by an all-ones accumulator or a set link.

A behavioural model in the bench predicts every result, and the `done` timing is checked on every clock.

// File: rtl/opr_pkg.sv
package opr_pkg;
    localparam int IR_W = 12;
    localparam logic [2:0] OPC_OPERATE = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_G1_CC,
        ST_G1_ROT,
        ST_G1_INC,
        ST_G2_SKIP,
        ST_G2_OSR,
        ST_G2_HLT,
        ST_DONE
    } opr_state_e;
endpackage

// File: rtl/opr_g1_alu.sv
module opr_g1_alu
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  opr_state_e       stage,
    input  logic [IR_W-1:0]  ir,
    input  logic [W-1:0]     acc,
    input  logic             lnk,
    output logic [W-1:0]     acc_nx,
    output logic             lnk_nx
);
    localparam int LW = W + 1;

    logic [LW-1:0] word;
    logic [LW-1:0] res;

    assign word = {lnk, acc};

    always_comb begin
        res = word;
        unique case (stage)
            ST_G1_CC: begin
                unique case ({ir[7], ir[5]})
                    2'b01:   res[W-1:0] = ~acc;
                    2'b10:   res[W-1:0] = '0;
                    2'b11:   res[W-1:0] = '1;
                    default: res[W-1:0] = acc;
                endcase
                unique case ({ir[6], ir[4]})
                    2'b01:   res[W] = ~lnk;
                    2'b10:   res[W] = 1'b0;
                    2'b11:   res[W] = 1'b1;
                    default: res[W] = lnk;
                endcase
            end
            ST_G1_ROT: begin
                unique case (ir[3:1])
                    3'd2:    res = {word[LW-2:0], word[LW-1]};
                    3'd3:    res = {word[LW-3:0], word[LW-1:LW-2]};
                    3'd4:    res = {word[0], word[LW-1:1]};
                    3'd5:    res = {word[1:0], word[LW-1:2]};
                    default: res = word;
                endcase
            end
            ST_G1_INC: begin
                if (ir[0]) res = word + LW'(1);
            end
            default: res = word;
        endcase
    end

    assign acc_nx = res[W-1:0];
    assign lnk_nx = res[W];
endmodule

// File: rtl/opr_g2_alu.sv
module opr_g2_alu
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  opr_state_e       stage,
    input  logic [IR_W-1:0]  ir,
    input  logic [W-1:0]     acc,
    input  logic             lnk,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     sw,
    input  logic             halt,
    output logic [W-1:0]     acc_nx,
    output logic [W-1:0]     pc_nx,
    output logic             halt_nx
);
    logic test_hit;

    assign test_hit = (ir[6] & acc[W-1]) | (ir[5] & (acc == '0)) | (ir[4] & lnk);

    always_comb begin
        acc_nx  = acc;
        pc_nx   = pc;
        halt_nx = halt;
        unique case (stage)
            ST_G2_SKIP: begin
                if (ir[7]) acc_nx = '0;
                if (test_hit ^ ir[3]) pc_nx = pc + W'(1);
            end
            ST_G2_OSR: begin
                if (ir[2]) acc_nx = acc | sw;
            end
            ST_G2_HLT: begin
                if (ir[1]) halt_nx = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IR_W-1:0]  ir_in,
    input  logic [W-1:0]     acc_in,
    input  logic             link_in,
    input  logic [W-1:0]     pc_in,
    input  logic [W-1:0]     sw_in,
    output logic [W-1:0]     acc_out,
    output logic             link_out,
    output logic [W-1:0]     pc_out,
    output logic             halt_out,
    output logic             done,
    output logic             busy
);
    opr_state_e state_q, state_d;

    logic [IR_W-1:0] ir_q;
    logic [W-1:0]    acc_q, pc_q, sw_q;
    logic            lnk_q, halt_q;

    logic [W-1:0]    g1_acc, g2_acc, g2_pc;
    logic            g1_lnk, g2_halt;
    logic            in_g1, in_g2;

    opr_g1_alu #(.W(W)) u_g1 (
        .stage  (state_q),
        .ir     (ir_q),
        .acc    (acc_q),
        .lnk    (lnk_q),
        .acc_nx (g1_acc),
        .lnk_nx (g1_lnk)
    );

    opr_g2_alu #(.W(W)) u_g2 (
        .stage   (state_q),
        .ir      (ir_q),
        .acc     (acc_q),
        .lnk     (lnk_q),
        .pc      (pc_q),
        .sw      (sw_q),
        .halt    (halt_q),
        .acc_nx  (g2_acc),
        .pc_nx   (g2_pc),
        .halt_nx (g2_halt)
    );

    assign in_g1 = (state_q == ST_G1_CC) || (state_q == ST_G1_ROT) || (state_q == ST_G1_INC);
    assign in_g2 = (state_q == ST_G2_SKIP) || (state_q == ST_G2_OSR) || (state_q == ST_G2_HLT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (ir_in[11:9] != OPC_OPERATE) state_d = ST_DONE;
                    else if (!ir_in[8])             state_d = ST_G1_CC;
                    else if (!ir_in[0])             state_d = ST_G2_SKIP;
                    else                            state_d = ST_DONE;
                end
            end
            ST_G1_CC:   state_d = ST_G1_ROT;
            ST_G1_ROT:  state_d = ST_G1_INC;
            ST_G1_INC:  state_d = ST_DONE;
            ST_G2_SKIP: state_d = ST_G2_OSR;
            ST_G2_OSR:  state_d = ST_G2_HLT;
            ST_G2_HLT:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q   <= '0;
            acc_q  <= '0;
            pc_q   <= '0;
            sw_q   <= '0;
            lnk_q  <= 1'b0;
            halt_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            ir_q   <= ir_in;
            acc_q  <= acc_in;
            pc_q   <= pc_in;
            sw_q   <= sw_in;
            lnk_q  <= link_in;
            halt_q <= 1'b0;
        end else if (in_g1) begin
            acc_q <= g1_acc;
            lnk_q <= g1_lnk;
        end else if (in_g2) begin
            acc_q  <= g2_acc;
            pc_q   <= g2_pc;
            halt_q <= g2_halt;
        end
    end

    always_comb begin
        acc_out  = acc_q;
        link_out = lnk_q;
        pc_out   = pc_q;
        halt_out = halt_q;
        done     = (state_q == ST_DONE);
        busy     = in_g1 || in_g2;
    end
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input logic       clk,
    input logic       rst_n,
    input opr_state_e state_q,
    input logic [W-1:0] pc,
    input logic       lnk,
    input logic       halt,
    input logic       done,
    input logic       busy
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_G1_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_G1_ROT || state_q == ST_G1_INC) |-> $stable(pc)); // R6

    AST_G2_PC_AFTER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_G2_HLT) |-> $stable(pc)); // R7

    AST_G2_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_G2_OSR || state_q == ST_G2_HLT) |-> $stable(lnk)); // R10

    AST_HALT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(state_q) == ST_G2_HLT); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R11
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .pc      (pc_out),
    .lnk     (link_out),
    .halt    (halt_out),
    .done    (done),
    .busy    (busy)
);

// File: tb/opr_unit_bench.sv
module opr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] ir_in = '0, acc_in = '0, pc_in = '0, sw_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] acc_out, pc_out;
    logic        link_out, halt_out, done, busy;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    opr_unit u_opr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ir_in(ir_in),
        .acc_in(acc_in), .link_in(link_in), .pc_in(pc_in), .sw_in(sw_in),
        .acc_out(acc_out), .link_out(link_out), .pc_out(pc_out),
        .halt_out(halt_out), .done(done), .busy(busy)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0o expected %0o", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: integers on the 13-bit {link,acc} value.
    task automatic model(input int ir, input int ac, input int l, input int pc, input int sw,
                         output int eac, output int el, output int epc, output int eh,
                         output int lat);
        int irb[12];
        int v;
        int rot;
        int skip;
        for (int k = 0; k < 12; k++) irb[k] = (ir >> (11 - k)) & 1;
        eac = ac; el = l; epc = pc; eh = 0; lat = 1;
        if ((ir >> 9) != 7 || (irb[3] == 1 && irb[11] == 1)) return;
        lat = 4;
        if (irb[3] == 0) begin
            if (irb[4] && irb[6]) eac = 4095;
            else if (irb[4])      eac = 0;
            else if (irb[6])      eac = 4095 - eac;
            if (irb[5] && irb[7]) el = 1;
            else if (irb[5])      el = 0;
            else if (irb[7])      el = 1 - el;
            v = el * 4096 + eac;
            rot = irb[8] * 4 + irb[9] * 2 + irb[10];
            if (rot == 2) v = ((v * 2) + (v / 4096)) % 8192;
            if (rot == 3) v = ((v * 4) + (v / 2048)) % 8192;
            if (rot == 4) v = (v / 2) + (v % 2) * 4096;
            if (rot == 5) v = (v / 4) + (v % 4) * 2048;
            if (irb[11] == 1) v = (v + 1) % 8192;
            el = v / 4096; eac = v % 4096;
        end else begin
            skip = 0;
            if (irb[5] && eac >= 2048) skip = 1;
            if (irb[6] && eac == 0)    skip = 1;
            if (irb[7] && el == 1)     skip = 1;
            if (skip != irb[8]) epc = (epc + 1) % 4096;
            if (irb[4]) eac = 0;
            if (irb[9]) eac = eac | sw;
            if (irb[10]) eh = 1;
        end
    endtask

    task automatic run(input string tag, input int ir, input int ac, input int l,
                       input int pc, input int sw);
        int eac, el, epc, eh, lat;
        model(ir, ac, l, pc, sw, eac, el, epc, eh, lat);
        @(negedge clk);
        ir_in = 12'(ir); acc_in = 12'(ac); link_in = l[0]; pc_in = 12'(pc); sw_in = 12'(sw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Compare done against the model on every clock (R11 timing).
        for (int c = 1; c <= lat; c++) begin
            check(tag, "done", int'(done), (c == lat) ? 1 : 0);
            if (c < lat) begin
                check("R11", "busy", int'(busy), (lat == 4) ? 1 : 0);
                @(negedge clk);
            end
        end
        check(tag, "acc", int'(acc_out), eac);
        check(tag, "link", int'(link_out), el);
        check(tag, "pc", int'(pc_out), epc);
        check(tag, "halt", int'(halt_out), eh);
        @(negedge clk);
        check("R11", "done drop", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", "acc", int'(acc_out), 0);
        check("R1", "link", int'(link_out), 0);
        check("R1", "pc", int'(pc_out), 0);
        check("R1", "halt", int'(halt_out), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "busy", int'(busy), 0);
        rst_n = 1'b1;

        run("R2", 'o7040, 'o1234, 0, 'o100, 0);
        run("R2", 'o7200, 'o1234, 1, 'o100, 0);
        run("R2", 'o7240, 'o0012, 0, 'o100, 0);
        run("R3", 'o7020, 0, 0, 'o100, 0);
        run("R3", 'o7100, 0, 1, 'o100, 0);
        run("R3", 'o7120, 0, 0, 'o100, 0);
        run("R4", 'o7004, 'o4001, 0, 'o10, 0);
        run("R4", 'o7006, 'o6001, 1, 'o10, 0);
        run("R4", 'o7010, 'o0003, 0, 'o10, 0);
        run("R4", 'o7012, 'o0003, 1, 'o10, 0);
        run("R4", 'o7002, 'o1234, 1, 'o10, 0);
        run("R4", 'o7014, 'o1234, 1, 'o10, 0);
        run("R5", 'o7001, 'o7777, 0, 'o10, 0);
        run("R5", 'o7001, 'o7777, 1, 'o10, 0);
        run("R6", 'o7241, 'o0055, 0, 'o20, 0);
        run("R6", 'o7204, 'o1111, 1, 'o20, 0);
        run("R6", 'o7041, 'o0005, 0, 'o20, 0);
        run("R7", 'o7500, 'o4000, 0, 'o30, 0);
        run("R7", 'o7440, 'o0000, 0, 'o30, 0);
        run("R7", 'o7420, 'o0001, 1, 'o30, 0);
        run("R7", 'o7410, 'o0001, 0, 'o7777, 0);
        run("R7", 'o7640, 'o0005, 0, 'o30, 0);
        run("R7", 'o7640, 'o0000, 0, 'o30, 0);
        run("R8", 'o7600, 'o3333, 1, 'o30, 0);
        run("R9", 'o7404, 'o1200, 0, 'o30, 'o0034);
        run("R9", 'o7604, 'o1234, 0, 'o30, 'o0055);
        run("R10", 'o7402, 'o1234, 1, 'o30, 0);
        run("R10", 'o7422, 'o0000, 1, 'o30, 0);
        run("R12", 'o1234, 'o4321, 1, 'o40, 'o7777);
        run("R12", 'o7401, 'o4321, 0, 'o40, 'o7777);

        for (int i = 0; i < 300; i++) begin
            int ir;
            ir = (i % 10 == 0) ? int'($urandom % 4096) : ('o7000 | int'($urandom % 512));
            run("R6", ir, int'($urandom % 4096), int'($urandom % 2),
                int'($urandom % 4096), int'($urandom % 4096));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule